// File: doc/BRIEF.md
# Local Memory Bus Responder with Mainboard Inhibit

This block sits on a 32-bit processor bus that starts each transfer with a one-cycle start strobe and ends each beat with an acknowledge. It decides whether on-card memory answers a transfer, and it generates the acknowledge timing for single transfers and four-beat line bursts. When the on-card processor owns the bus, the block serves it directly. When another master owns the bus, for example a DMA engine, the block decodes the address in the same way. For a hit it drives an inhibit line that keeps the mainboard memory controller silent, and it then terminates the transfer itself.

The memory array lies behind a simple request/ready port with in-order read returns. Once a read burst completes, the block fetches the following 16-byte line into a one-line buffer. A burst to that line is then acknowledged in every clock with no setup cycle. Any write that hits the buffered line invalidates it.

Top module: `lbus_responder`

## Requirements
- R1: While reset is held and after it is released with no start strobe, bus_ta, mem_inhibit and mem_req are all low.
- R2: A transfer hits only when the enable is set and address bits [31:20], XORed with cfg_win_base and then shifted right by cfg_win_lg, give zero. A transfer that misses never produces bus_ta, mem_inhibit or mem_req.
- R3: A hit while bus_cpu_own is 1 never raises mem_inhibit.
- R4: A hit while bus_cpu_own is 0 raises mem_inhibit in the cycle the start strobe is sampled. It stays high through the cycle of the last acknowledge and is low in the cycle after.
- R5: With a zero-wait memory, a read that misses the line buffer acknowledges its first beat one cycle after the start cycle. Each later burst beat follows in the next cycle (2-1-1-1).
- R6: Burst beat k carries longword (w0+k) mod 4 of the aligned 16-byte line, where w0 is address bits [3:2].
- R7: A transfer with bus_burst=0 receives exactly one acknowledge.
- R8: When a read burst completes and the next line is inside the window, that line is fetched into the buffer. A later read to it is acknowledged in the start cycle and in every following cycle (1-1-1-1), using the buffered data.
- R9: A write that hits the buffered line invalidates it, so a later read of that line takes the 2-cycle path and returns the written data.
- R10: Write beat k takes the bus_wdata present in its acknowledge cycle and stores it at the wrapped longword address of R6. With a zero-wait memory, the beats are acknowledged in cycles 1 to 4 after the start.
- R11: A hitting start strobe that arrives while a transfer is active is held pending and starts in the first idle cycle. The two transfers never overlap. If the pending transfer comes from a foreign master, it keeps mem_inhibit high while it waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_win_en | input | 1 | Enables the local window |
| cfg_win_base | input | 12 | Window base, address bits [31:20] |
| cfg_win_lg | input | 4 | log2 of window size in 1 MB blocks |
| bus_cpu_own | input | 1 | 1 when the on-card processor is bus master |
| bus_ts | input | 1 | Transfer start strobe, one cycle |
| bus_addr | input | 32 | Transfer address |
| bus_read | input | 1 | 1 = read, 0 = write |
| bus_burst | input | 1 | 1 = four-beat line burst |
| bus_wdata | input | 32 | Write data of the current beat |
| bus_ta | output | 1 | Beat acknowledge |
| bus_rdata | output | 32 | Read data, valid with bus_ta |
| mem_inhibit | output | 1 | Silences the mainboard memory controller |
| mem_req | output | 1 | Memory longword request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Request byte address |
| mem_wdata | output | 32 | Request write data |
| mem_ready | input | 1 | Memory accepts the request |
| mem_rvalid | input | 1 | Read data return, in request order |
| mem_rdata | input | 32 | Read return data |

## Verification
The hardest case to reach is a start strobe that arrives while the block is busy, and in particular one from a foreign master. In that case inhibit has to be driven from the pending record and not from an active transfer. The bench issues a single local read and, one clock later, a foreign read. It then checks the acknowledge cycles and the inhibit pattern cycle by cycle. The path that serves bursts from the buffer and its invalidation also need a set sequence. A burst first fills the next line, a second burst consumes that line and starts the next fill, and a foreign write then lands inside the freshly fetched line before that line is read back.

// File: rtl/lbr_pkg.sv
`timescale 1ns/1ps
// Shared types for the local bus responder.
package lbr_pkg;

    // Responder sequencing states.
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a start strobe or a pending transfer
        ST_RD,     // read served from the memory port
        ST_WR,     // write forwarded to the memory port
        ST_BUF,    // read served from the line buffer
        ST_FILL    // fetching the next line into the buffer
    } lbr_state_e;

endpackage

// File: rtl/lbr_win_decode.sv
`timescale 1ns/1ps
// Window decoder: compares the upper address block number with a base,
// ignoring as many low block bits as the size exponent gives.
// Assumes the window is aligned to its own power-of-two size.
module lbr_win_decode #(
    parameter int BLK_W = 12,
    parameter int LG_W  = 4
) (
    input  logic [BLK_W-1:0] blk,
    input  logic             en,
    input  logic [BLK_W-1:0] base,
    input  logic [LG_W-1:0]  size_lg,
    output logic             hit
);
    logic [BLK_W-1:0] diff;

    // Hit when every compared block bit matches the base.
    always_comb begin
        diff = blk ^ base;
        hit  = en && ((diff >> size_lg) == '0);
    end
endmodule

// File: rtl/lbr_line_buf.sv
`timescale 1ns/1ps
// One-line prefetch buffer: a tag, a valid flag and BEATS data words.
// A fill start clears valid and loads the tag, words arrive by index,
// and fill_done sets valid. Invalidation has priority over fill_done.
module lbr_line_buf #(
    parameter int LINE_W = 28,
    parameter int DATA_W = 32,
    parameter int BEATS  = 4,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_start,
    input  logic [LINE_W-1:0] fill_line,
    input  logic              fill_we,
    input  logic [BEAT_W-1:0] fill_idx,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              fill_done,
    input  logic              inval,
    input  logic [LINE_W-1:0] q_line,
    input  logic [BEAT_W-1:0] q_idx,
    output logic              q_hit,
    output logic [DATA_W-1:0] q_data
);
    logic              valid_q;
    logic [LINE_W-1:0] tag_q;
    logic [DATA_W-1:0] words [BEATS];

    // Tag and valid bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            tag_q   <= '0;
        end else if (fill_start) begin
            valid_q <= 1'b0;
            tag_q   <= fill_line;
        end else if (inval) begin
            valid_q <= 1'b0;
        end else if (fill_done) begin
            valid_q <= 1'b1;
        end
    end

    // One storage word per beat, each written by its own index match.
    for (genvar g = 0; g < BEATS; g++) begin : g_word
        logic [DATA_W-1:0] word_q;
        // Capture returning fill data for this beat slot.
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q <= '0;
            else if (fill_we && fill_idx == BEAT_W'(g))
                word_q <= fill_data;
        end
        assign words[g] = word_q;
    end

    // Lookup against the stored tag.
    always_comb begin
        q_hit  = valid_q && (tag_q == q_line);
        q_data = words[q_idx];
    end
endmodule

// File: rtl/lbus_responder.sv
`timescale 1ns/1ps
// Local memory bus responder. Answers bus transfers that fall in a
// configurable window, for the on-card processor or a foreign master,
// and drives inhibit toward the mainboard memory controller for foreign hits.
// Assumes: one outstanding transfer per master, memory returns reads in order,
// bus ownership is stable for the length of a transfer.
module lbus_responder #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_BEATS = 4,
    parameter int WIN_SHIFT  = 20
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_win_en,
    input  logic [ADDR_W-WIN_SHIFT-1:0]   cfg_win_base,
    input  logic [$clog2(ADDR_W-WIN_SHIFT+1)-1:0] cfg_win_lg,
    input  logic                          bus_cpu_own,
    input  logic                          bus_ts,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic                          bus_read,
    input  logic                          bus_burst,
    input  logic [DATA_W-1:0]             bus_wdata,
    output logic                          bus_ta,
    output logic [DATA_W-1:0]             bus_rdata,
    output logic                          mem_inhibit,
    output logic                          mem_req,
    output logic                          mem_we,
    output logic [ADDR_W-1:0]             mem_addr,
    output logic [DATA_W-1:0]             mem_wdata,
    input  logic                          mem_ready,
    input  logic                          mem_rvalid,
    input  logic [DATA_W-1:0]             mem_rdata
);
    import lbr_pkg::*;

    localparam int BYTE_W = $clog2(DATA_W/8);
    localparam int BEAT_W = $clog2(LINE_BEATS);
    localparam int OFF_W  = BYTE_W + BEAT_W;
    localparam int LINE_W = ADDR_W - OFF_W;
    localparam int BLK_W  = ADDR_W - WIN_SHIFT;
    localparam int LG_W   = $clog2(BLK_W + 1);
    localparam int CNT_W  = BEAT_W + 1;

    lbr_state_e             st;
    logic [LINE_W-1:0]      xf_line;
    logic [BEAT_W-1:0]      xf_word;
    logic                   xf_burst;
    logic                   xf_foreign;
    logic [CNT_W-1:0]       req_cnt;
    logic [CNT_W-1:0]       ack_cnt;
    logic                   pend_v;
    logic [ADDR_W-1:BYTE_W] pend_addr;
    logic                   pend_read;
    logic                   pend_burst;
    logic                   pend_foreign;

    logic                   live_hit, live_go, nxt_hit;
    logic                   s_go, s_read, s_burst, s_foreign;
    logic [LINE_W-1:0]      s_line, nxt_line, q_line;
    logic [BEAT_W-1:0]      s_word, q_idx, req_word, ack_word;
    logic [CNT_W-1:0]       n_beats, last_cnt;
    logic                   buf_hit, buf_inval, fill_start, fill_done, fin_rd;
    logic [DATA_W-1:0]      buf_data;
    logic [ADDR_W-1:0]      nxt_addr;
    logic                   unused_addr_lsb;

    assign unused_addr_lsb = ^bus_addr[BYTE_W-1:0];

    // Window decode for the live bus address.
    lbr_win_decode #(.BLK_W(BLK_W), .LG_W(LG_W)) u_dec_live (
        .blk(bus_addr[ADDR_W-1:WIN_SHIFT]), .en(cfg_win_en),
        .base(cfg_win_base), .size_lg(cfg_win_lg), .hit(live_hit));

    // Window decode for the line after the current transfer.
    lbr_win_decode #(.BLK_W(BLK_W), .LG_W(LG_W)) u_dec_next (
        .blk(nxt_addr[ADDR_W-1:WIN_SHIFT]), .en(cfg_win_en),
        .base(cfg_win_base), .size_lg(cfg_win_lg), .hit(nxt_hit));

    lbr_line_buf #(.LINE_W(LINE_W), .DATA_W(DATA_W),
                   .BEATS(LINE_BEATS), .BEAT_W(BEAT_W)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .fill_start(fill_start), .fill_line(nxt_line),
        .fill_we(st == ST_FILL && mem_rvalid), .fill_idx(ack_cnt[BEAT_W-1:0]),
        .fill_data(mem_rdata), .fill_done(fill_done), .inval(buf_inval),
        .q_line(q_line), .q_idx(q_idx), .q_hit(buf_hit), .q_data(buf_data));

    // Start selection: a pending transfer wins over a live strobe.
    always_comb begin
        live_go   = bus_ts && live_hit;
        s_go      = (st == ST_IDLE) && (pend_v || live_go);
        s_read    = pend_v ? pend_read    : bus_read;
        s_burst   = pend_v ? pend_burst   : bus_burst;
        s_foreign = pend_v ? pend_foreign : !bus_cpu_own;
        s_line    = pend_v ? pend_addr[ADDR_W-1:OFF_W] : bus_addr[ADDR_W-1:OFF_W];
        s_word    = pend_v ? pend_addr[OFF_W-1:BYTE_W] : bus_addr[OFF_W-1:BYTE_W];
        nxt_line  = xf_line + LINE_W'(1);
        nxt_addr  = {nxt_line, {OFF_W{1'b0}}};
        n_beats   = xf_burst ? CNT_W'(LINE_BEATS) : CNT_W'(1);
        last_cnt  = xf_burst ? CNT_W'(LINE_BEATS - 1) : '0;
        req_word  = xf_word + req_cnt[BEAT_W-1:0];
        ack_word  = xf_word + ack_cnt[BEAT_W-1:0];
        q_line    = s_go ? s_line : xf_line;
        q_idx     = s_go ? s_word : ack_word;
    end

    // Bus-side and memory-side outputs per state.
    always_comb begin
        bus_ta    = 1'b0;
        bus_rdata = '0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = bus_wdata;
        fin_rd    = 1'b0;
        fill_done = 1'b0;
        case (st)
            ST_IDLE: if (s_go && s_read) begin
                if (buf_hit) begin
                    bus_ta    = 1'b1;
                    bus_rdata = buf_data;
                end else begin
                    mem_req  = 1'b1;
                    mem_addr = {s_line, s_word, {BYTE_W{1'b0}}};
                end
            end
            ST_RD: begin
                mem_req   = req_cnt < n_beats;
                mem_addr  = {xf_line, req_word, {BYTE_W{1'b0}}};
                bus_ta    = mem_rvalid;
                bus_rdata = mem_rdata;
                fin_rd    = mem_rvalid && ack_cnt == last_cnt;
            end
            ST_WR: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = {xf_line, ack_word, {BYTE_W{1'b0}}};
                bus_ta   = mem_ready;
            end
            ST_BUF: begin
                bus_ta    = 1'b1;
                bus_rdata = buf_data;
                fin_rd    = ack_cnt == last_cnt;
            end
            ST_FILL: begin
                mem_req   = req_cnt < CNT_W'(LINE_BEATS);
                mem_addr  = {xf_line, req_cnt[BEAT_W-1:0], {BYTE_W{1'b0}}};
                fill_done = mem_rvalid && ack_cnt == CNT_W'(LINE_BEATS - 1);
            end
            default: ;
        endcase
        fill_start  = fin_rd && xf_burst && nxt_hit;
        buf_inval   = s_go && !s_read && buf_hit;
        mem_inhibit = ((st == ST_RD || st == ST_WR || st == ST_BUF) && xf_foreign)
                    || (pend_v && pend_foreign)
                    || (live_go && !pend_v && !bus_cpu_own);
    end

    // Transfer sequencing, beat counting and pending capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE; xf_line <= '0; xf_word <= '0; xf_burst <= 1'b0;
            xf_foreign <= 1'b0; req_cnt <= '0; ack_cnt <= '0;
            pend_v <= 1'b0; pend_addr <= '0; pend_read <= 1'b0;
            pend_burst <= 1'b0; pend_foreign <= 1'b0;
        end else begin
            if (st != ST_IDLE && live_go && !pend_v) begin
                pend_v       <= 1'b1;
                pend_addr    <= bus_addr[ADDR_W-1:BYTE_W];
                pend_read    <= bus_read;
                pend_burst   <= bus_burst;
                pend_foreign <= !bus_cpu_own;
            end
            case (st)
                ST_IDLE: if (s_go) begin
                    pend_v     <= 1'b0;
                    xf_line    <= s_line;
                    xf_word    <= s_word;
                    xf_burst   <= s_burst;
                    xf_foreign <= s_foreign;
                    ack_cnt    <= '0;
                    req_cnt    <= '0;
                    if (s_read && buf_hit) begin
                        ack_cnt <= CNT_W'(1);
                        st      <= s_burst ? ST_BUF : ST_IDLE;
                    end else if (s_read) begin
                        req_cnt <= CNT_W'(mem_ready);
                        st      <= ST_RD;
                    end else begin
                        st      <= ST_WR;
                    end
                end
                ST_RD, ST_BUF: begin
                    if (mem_req && mem_ready) req_cnt <= req_cnt + CNT_W'(1);
                    if (bus_ta) ack_cnt <= ack_cnt + CNT_W'(1);
                    if (fin_rd) begin
                        if (fill_start) begin
                            st      <= ST_FILL;
                            xf_line <= nxt_line;
                            req_cnt <= '0;
                            ack_cnt <= '0;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                ST_WR: if (mem_ready) begin
                    ack_cnt <= ack_cnt + CNT_W'(1);
                    if (ack_cnt == last_cnt) st <= ST_IDLE;
                end
                ST_FILL: begin
                    if (mem_req && mem_ready) req_cnt <= req_cnt + CNT_W'(1);
                    if (mem_rvalid) ack_cnt <= ack_cnt + CNT_W'(1);
                    if (fill_done) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lbus_responder_chk.sv
`timescale 1ns/1ps
// Protocol checker for lbus_responder, attached by bind.
module lbus_responder_chk (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_cpu_own,
    input logic                bus_ts,
    input logic                bus_ta,
    input logic                mem_inhibit,
    input logic                mem_req,
    input logic                pend_v,
    input logic                buf_hit,
    input lbr_pkg::lbr_state_e st
);
    import lbr_pkg::*;

    // R3
    inhib_foreign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_inhibit |-> !bus_cpu_own);

    // R2
    ack_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ta |-> (st != ST_IDLE || bus_ts || pend_v));

    // R2
    req_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && st == ST_IDLE) |-> (bus_ts || pend_v));

    // R8
    buf_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BUF) |-> bus_ta);

    // R9
    wr_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WR) |-> !buf_hit);

    // R11
    pend_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_v && st == ST_IDLE) |=> !pend_v);
endmodule

bind lbus_responder lbus_responder_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_cpu_own(bus_cpu_own), .bus_ts(bus_ts),
    .bus_ta(bus_ta), .mem_inhibit(mem_inhibit), .mem_req(mem_req),
    .pend_v(pend_v), .buf_hit(buf_hit), .st(st));

// File: tb/lbus_responder_tb.sv
`timescale 1ns/1ps
module lbus_responder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_win_en = 1'b1;
    logic [11:0] cfg_win_base = 12'h100;
    logic [3:0]  cfg_win_lg = 4'd0;
    logic        bus_cpu_own = 1'b1, bus_ts = 1'b0, bus_read = 1'b1, bus_burst = 1'b0;
    logic [31:0] bus_addr = '0, bus_wdata = '0;
    logic        bus_ta, mem_inhibit, mem_req, mem_we;
    logic [31:0] bus_rdata, mem_addr, mem_wdata, mem_rdata;
    logic        mem_ready = 1'b1, mem_rvalid;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    logic        ta_log [16];
    logic        inh_log[16];
    logic        req_log[16];
    logic [31:0] rd_log [16];
    logic [31:0] mem_arr[256];

    always #4 clk = ~clk;

    lbus_responder u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_win_en(cfg_win_en), .cfg_win_base(cfg_win_base),
        .cfg_win_lg(cfg_win_lg), .bus_cpu_own(bus_cpu_own), .bus_ts(bus_ts),
        .bus_addr(bus_addr), .bus_read(bus_read), .bus_burst(bus_burst),
        .bus_wdata(bus_wdata), .bus_ta(bus_ta), .bus_rdata(bus_rdata),
        .mem_inhibit(mem_inhibit), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata));

    // Zero-wait memory model: accepts every request, returns reads next cycle.
    initial for (int i = 0; i < 256; i++) mem_arr[i] = 32'hA000_0000 + 32'(i);
    always @(posedge clk) begin
        if (mem_req && mem_we) mem_arr[mem_addr[9:2]] <= mem_wdata;
        mem_rvalid <= rst_n && mem_req && !mem_we;
        mem_rdata  <= mem_arr[mem_addr[9:2]];
    end

    function automatic logic [31:0] initw(input int idx);
        return 32'hA000_0000 + 32'(idx);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One transfer from a negedge: start strobe in cycle 0, log n cycles.
    task automatic xfer(input logic [31:0] a, input logic rd, input logic bu,
                        input logic own, input logic [31:0] wb, input int n);
        bus_addr = a; bus_read = rd; bus_burst = bu; bus_cpu_own = own;
        for (int c = 0; c < n; c++) begin
            bus_ts = (c == 0);
            bus_wdata = wb + 32'(c) - 32'd1;
            #1;
            ta_log[c] = bus_ta; inh_log[c] = mem_inhibit;
            req_log[c] = mem_req; rd_log[c] = bus_rdata;
            @(negedge clk);
        end
        bus_ts = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 ta in reset", 32'(bus_ta), 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1 ta", 32'(bus_ta), 0);
        chk("R1 inhibit", 32'(mem_inhibit), 0);
        chk("R1 mem_req", 32'(mem_req), 0);
        @(negedge clk);
    endtask

    task automatic t_foreign_burst;
        int w[4] = '{18, 19, 16, 17};
        xfer(32'h1000_0048, 1, 1, 0, 0, 6);
        chk("R5 no ack in start cycle", 32'(ta_log[0]), 0);
        for (int k = 0; k < 4; k++) begin
            chk("R5 beat ack", 32'(ta_log[k+1]), 1);
            chk("R6 wrap data", rd_log[k+1], initw(w[k]));
        end
        chk("R5 no fifth ack", 32'(ta_log[5]), 0);
        for (int c = 0; c < 5; c++) chk("R4 inhibit held", 32'(inh_log[c]), 1);
        chk("R4 inhibit released", 32'(inh_log[5]), 0);
        idle(8);
    endtask

    task automatic t_prefetch_burst;
        int w[4] = '{21, 22, 23, 20};
        xfer(32'h1000_0054, 1, 1, 1, 0, 5);
        for (int k = 0; k < 4; k++) begin
            chk("R8 ack every cycle", 32'(ta_log[k]), 1);
            chk("R8 buffered data", rd_log[k], initw(w[k]));
            chk("R3 no inhibit local", 32'(inh_log[k]), 0);
        end
        chk("R8 done after four", 32'(ta_log[4]), 0);
        idle(8);
    endtask

    task automatic t_write_inval;
        xfer(32'h1000_0064, 0, 0, 0, 32'hDEAD_BEEF, 3);
        chk("R7 write single ack", 32'(ta_log[1]), 1);
        chk("R7 no second ack", 32'(ta_log[2]), 0);
        chk("R4 write inhibit", 32'(inh_log[1]), 1);
        chk("R4 write inhibit off", 32'(inh_log[2]), 0);
        idle(2);
        xfer(32'h1000_0060, 1, 1, 1, 0, 5);
        chk("R9 slow path after write", 32'(ta_log[0]), 0);
        chk("R9 first beat", rd_log[1], initw(24));
        chk("R9 written word", rd_log[2], 32'hDEAD_BEEF);
        chk("R9 last beat ack", 32'(ta_log[4]), 1);
        idle(8);
    endtask

    task automatic t_write_burst;
        logic [31:0] ra[4] = '{32'h1000_0088, 32'h1000_008C, 32'h1000_0080, 32'h1000_0084};
        xfer(32'h1000_0088, 0, 1, 1, 32'h5000_0000, 6);
        chk("R10 no ack at start", 32'(ta_log[0]), 0);
        for (int k = 1; k < 5; k++) chk("R10 write beat ack", 32'(ta_log[k]), 1);
        chk("R10 write done", 32'(ta_log[5]), 0);
        idle(2);
        for (int k = 0; k < 4; k++) begin
            xfer(ra[k], 1, 0, 1, 0, 3);
            chk("R10 readback", rd_log[1], 32'h5000_0000 + 32'(k));
            chk("R7 single read ack", 32'(ta_log[1]) + 32'(ta_log[2]), 1);
            idle(2);
        end
    endtask

    task automatic t_miss;
        xfer(32'h2000_0000, 1, 1, 0, 0, 6);
        for (int c = 0; c < 6; c++) begin
            chk("R2 miss no ack", 32'(ta_log[c]), 0);
            chk("R2 miss no inhibit", 32'(inh_log[c]), 0);
            chk("R2 miss no request", 32'(req_log[c]), 0);
        end
        cfg_win_lg = 4'd1;
        xfer(32'h1010_0008, 1, 0, 0, 0, 3);
        chk("R2 larger window hit", 32'(ta_log[1]), 1);
        chk("R2 larger window data", rd_log[1], initw(2));
        idle(2);
        cfg_win_lg = 4'd0;
        xfer(32'h1010_0008, 1, 0, 0, 0, 4);
        chk("R2 outside 1MB window", 32'(ta_log[1]) + 32'(ta_log[2]), 0);
        idle(2);
    endtask

    task automatic t_holdoff;
        bus_addr = 32'h1000_0100; bus_read = 1; bus_burst = 0; bus_cpu_own = 1;
        bus_ts = 1; #1;
        ta_log[0] = bus_ta; inh_log[0] = mem_inhibit;
        @(negedge clk);
        bus_addr = 32'h1000_0204; bus_cpu_own = 0; bus_ts = 1; #1;
        ta_log[1] = bus_ta; inh_log[1] = mem_inhibit; rd_log[1] = bus_rdata;
        @(negedge clk);
        bus_ts = 0;
        for (int c = 2; c < 5; c++) begin
            #1;
            ta_log[c] = bus_ta; inh_log[c] = mem_inhibit; rd_log[c] = bus_rdata;
            @(negedge clk);
        end
        chk("R11 first ack", 32'(ta_log[1]), 1);
        chk("R11 first data", rd_log[1], initw(64));
        chk("R11 held off", 32'(ta_log[2]), 0);
        chk("R11 second ack", 32'(ta_log[3]), 1);
        chk("R11 second data", rd_log[3], initw(129));
        chk("R11 single second ack", 32'(ta_log[4]), 0);
        chk("R3 local no inhibit", 32'(inh_log[0]), 0);
        chk("R11 inhibit at strobe", 32'(inh_log[1]), 1);
        chk("R11 inhibit pending", 32'(inh_log[2]), 1);
        chk("R11 inhibit active", 32'(inh_log[3]), 1);
        chk("R11 inhibit released", 32'(inh_log[4]), 0);
        idle(2);
    endtask

    initial begin
        t_reset();
        t_foreign_burst();
        t_prefetch_burst();
        t_write_inval();
        t_write_burst();
        t_miss();
        t_holdoff();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule